// File: doc/BRIEF.md
# Horizontal Line Clip Unit

The unit sits in a pixel stream between a line fetch engine and a compositor. Each source line arrives at full width. The unit keeps one horizontal window of that line and discards a programmed number of pixels on its left and on its right. Every input line still yields one output line, because height is never trimmed. Pixels enter and leave over valid/ready handshakes. The input marks the first pixel of a line (`in_sol`) and the last pixel of a frame (`in_eof`). The output adds an end-of-line marker.

Software programs three registers through a simple write port. The values first land in a shadow bank. They move into the working set only when the input accepts an end-of-frame pixel, so a running frame never changes its geometry partway through. A hold bit blocks that copy. Software can then stage a full new configuration over several frames and release it all at once. A bypass bit forwards every pixel with its markers unchanged. Bypass is how software selects a window as wide as the line, since the trim encoding cannot express that case.

Top module: `hline_clip`

## Requirements
- R1: After reset the working configuration is bypass. An input pixel appears unchanged at the output in the same cycle, `out_valid` is low while `in_valid` is low, and `in_ready` is high.
- R2: While the working bypass bit is 1, every input pixel passes with the same data, `out_sol` equals `in_sol`, and `out_eof` equals `in_eof`, whatever the trim values are.
- R3: The register at address 1 holds (line width − 1) in bits [31:16] and (frame height − 1) in bits [15:0].
- R4: The register at address 2 holds the left trim L in bits [31:16] and the right value R in bits [15:0]. With a line width of W, the kept columns are L through W−2−R, where column 0 is the pixel carrying `in_sol`.
- R5: The register at address 0 holds the bypass bit in bit 0 and the reload-hold bit in bit 1. The hold bit acts at once and is not shadowed.
- R6: In clip mode, `out_sol` is asserted on the first kept pixel of a line and on no other pixel. `out_eol` is asserted on the last kept pixel of a line.
- R7: In clip mode, `out_eof` is asserted on the last kept pixel of line number (height − 1) and on no other pixel.
- R8: A register write takes effect only after a pixel carrying `in_eof` has been accepted. Lines sent before that pixel use the previous values.
- R9: While the hold bit is 1, accepting an end-of-frame pixel does not copy the shadow values. Once the bit is cleared, the next end-of-frame pixel copies them.
- R10: A pixel outside the window is consumed (`in_ready` high) even when `out_ready` is low. A pixel inside the window waits for `out_ready`.
- R11: A pixel with `in_sol` restarts the column count at 0, even when the previous line was shorter than the programmed width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 size, 2 trim |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | DW | Input pixel value |
| in_sol | input | 1 | Input pixel is column 0 of a line |
| in_eof | input | 1 | Input pixel is the last of a frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take a pixel |
| out_data | output | DW | Output pixel value |
| out_sol | output | 1 | First pixel of an output line |
| out_eol | output | 1 | Last pixel of an output line |
| out_eof | output | 1 | Last pixel of an output frame |

## Verification
The end-of-frame pixel can fall in the same cycle as a change to the configuration that governs the pixels around it. That pixel decides its own fate under the old configuration, while also triggering the copy into the working set. The bench stages new trim values before that pixel and sends lines on both sides of it. It judges the result by the first kept column, which should show the old window before the boundary and the new one after. It also does this with the hold bit set, where the window must not move. A second coincidence is a trimmed pixel arriving while the output stalls. The bench drops `out_ready` and checks that trimmed columns are still consumed while the first kept column is held back.

// File: rtl/hlc_pkg.sv
// Package: shared register layout and working-configuration type for the
// horizontal line clip unit. Field widths follow the 16-bit register halves.
package hlc_pkg;
    localparam int FW = 16;                       // width of one register field
    localparam logic [1:0] A_CTL  = 2'd0;         // bypass / reload hold
    localparam logic [1:0] A_SIZE = 2'd1;         // width-1 | height-1
    localparam logic [1:0] A_TRIM = 2'd2;         // left | right value
    localparam int B_BYPASS = 0;
    localparam int B_HOLD   = 1;

    typedef struct packed {
        logic          bypass;
        logic [FW-1:0] wm1;     // line width minus one
        logic [FW-1:0] hm1;     // frame height minus one
        logic [FW-1:0] left;    // columns trimmed on the left
        logic [FW-1:0] right;   // right value: remaining columns minus one
    } hlc_cfg_t;
endpackage

// File: rtl/hlc_cfg_bank.sv
// Module: shadow and working register bank.
// Writes land in the shadow set. The working set is refreshed from the
// shadow when frame_end pulses, unless the hold bit is set. The hold bit
// itself acts immediately. Assumes frame_end is a one-cycle pulse per
// accepted end-of-frame pixel.
module hlc_cfg_bank
    import hlc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    input  logic        frame_end,
    output hlc_cfg_t    live,
    output logic        hold
);
    hlc_cfg_t shadow;
    logic     ctl_unused;

    assign ctl_unused = ^wdata[31:2];

    // Capture software writes into the shadow set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '{bypass: 1'b1, default: '0};
        end else if (we) begin
            case (addr)
                A_CTL:   shadow.bypass <= wdata[B_BYPASS];
                A_SIZE:  begin
                    shadow.wm1 <= wdata[31:16];
                    shadow.hm1 <= wdata[15:0];
                end
                A_TRIM:  begin
                    shadow.left  <= wdata[31:16];
                    shadow.right <= wdata[15:0];
                end
                default: ;
            endcase
        end
    end

    // Reload-hold bit, effective without waiting for frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= 1'b0;
        else if (we && addr == A_CTL)
            hold <= wdata[B_HOLD];
    end

    // Copy shadow into the working set at frame end unless held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live <= '{bypass: 1'b1, default: '0};
        else if (frame_end && !hold)
            live <= shadow;
    end
endmodule

// File: rtl/hlc_window.sv
// Module: column/row tracker and window decision.
// Tracks the column of the presented pixel (forced to 0 by sol) and the
// line index within the frame. It flags whether that column lies inside
// [left, wm1-right-1] and whether it is the first or last kept column.
// Assumes fire marks an accepted pixel.
module hlc_window #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] wm1,
    input  logic [FW-1:0] left,
    input  logic [FW-1:0] right,
    input  logic          px_sol,
    input  logic          px_eof,
    input  logic          fire,
    output logic          keep,
    output logic          first,
    output logic          last,
    output logic          line_end,
    output logic [FW-1:0] row
);
    localparam int SW = FW + 2;

    logic [FW-1:0]        col_q, cur_col;
    logic [FW-1:0]        row_q;
    logic signed [SW-1:0] col_s, left_s, last_s;

    assign cur_col  = px_sol ? '0 : col_q;
    assign col_s    = $signed({2'b00, cur_col});
    assign left_s   = $signed({2'b00, left});
    assign last_s   = $signed({2'b00, wm1}) - $signed({2'b00, right}) - SW'(1);
    assign keep     = (col_s >= left_s) && (col_s <= last_s);
    assign first    = (col_s == left_s);
    assign last     = (col_s == last_s);
    assign line_end = (cur_col == wm1);
    assign row      = row_q;

    // Advance column and row on each accepted pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (fire) begin
            if (px_eof) begin
                col_q <= '0;
                row_q <= '0;
            end else if (line_end) begin
                col_q <= '0;
                row_q <= row_q + FW'(1);
            end else begin
                col_q <= cur_col + FW'(1);
            end
        end
    end
endmodule

// File: rtl/hline_clip.sv
// Module: horizontal line clip unit (top).
// Forwards the kept window of each line with no added latency. Trimmed
// pixels are consumed without waiting for the output. Bypass forwards
// everything with the input markers. Assumes the input sends lines of the
// programmed width, each starting with sol.
module hline_clip #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_sol,
    input  logic          in_eof,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic          out_sol,
    output logic          out_eol,
    output logic          out_eof
);
    import hlc_pkg::*;

    hlc_cfg_t      cfg_live;
    logic          cfg_hold;
    logic          fire, keep, win_keep, win_first, win_last, line_end;
    logic [FW-1:0] row;

    hlc_cfg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .frame_end (fire && in_eof),
        .live      (cfg_live),
        .hold      (cfg_hold)
    );

    hlc_window #(.FW(FW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .wm1      (cfg_live.wm1),
        .left     (cfg_live.left),
        .right    (cfg_live.right),
        .px_sol   (in_sol),
        .px_eof   (in_eof),
        .fire     (fire),
        .keep     (win_keep),
        .first    (win_first),
        .last     (win_last),
        .line_end (line_end),
        .row      (row)
    );

    // Handshake: trimmed pixels never wait on the output.
    always_comb begin
        keep      = cfg_live.bypass || win_keep;
        in_ready  = !keep || out_ready;
        out_valid = in_valid && keep;
        fire      = in_valid && in_ready;
        out_data  = in_data;
    end

    // Output markers: copied in bypass, regenerated from the window otherwise.
    always_comb begin
        if (cfg_live.bypass) begin
            out_sol = in_sol;
            out_eol = line_end;
            out_eof = in_eof;
        end else begin
            out_sol = win_keep && win_first;
            out_eol = win_keep && win_last;
            out_eof = win_keep && win_last && (row == cfg_live.hm1);
        end
    end
endmodule

// File: rtl/hlc_chk.sv
// Module: protocol and reload checker bound to hline_clip.
// Observes the pixel handshakes and the working configuration.
module hlc_chk #(
    parameter int DW = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_eof,
    input logic              out_valid,
    input logic              out_ready,
    input hlc_pkg::hlc_cfg_t cfg_live,
    input logic              cfg_hold
);
    AST_DROP_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_valid) |-> in_ready); // R10
    AST_KEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R10
    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_valid); // R6
    AST_BYPASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cfg_live.bypass) |-> out_valid); // R2
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hold |=> $stable(cfg_live)); // R9
    AST_RELOAD_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready && in_eof) |=> $stable(cfg_live)); // R8
endmodule

bind hline_clip hlc_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_eof    (in_eof),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .cfg_live  (cfg_live),
    .cfg_hold  (cfg_hold)
);

// File: tb/tb_hline_clip.sv
module tb_hline_clip;
    localparam int DW = 24;

    typedef struct packed {
        logic       byp;
        logic [7:0] wm1;
        logic [7:0] left;
        logic [7:0] right;
        logic [7:0] nkeep;
        logic [7:0] first;
    } vec_t;

    // Kept columns: left .. wm1-right-1 (R4); bypass keeps all (R2).
    localparam vec_t VEC [5] = '{
        '{1'b0, 8'd9,  8'd2, 8'd2, 8'd5,  8'd2},
        '{1'b0, 8'd7,  8'd0, 8'd0, 8'd7,  8'd0},
        '{1'b0, 8'd5,  8'd3, 8'd1, 8'd1,  8'd3},
        '{1'b1, 8'd5,  8'd2, 8'd1, 8'd6,  8'd0},
        '{1'b0, 8'd11, 8'd5, 8'd0, 8'd6,  8'd5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          in_valid = 1'b0, in_sol = 1'b0, in_eof = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready, out_valid, out_sol, out_eol, out_eof;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;

    int n_chk = 0, n_fail = 0;
    int rec_cnt, rec_eol_cnt, rec_eof_cnt, rec_sol_bad;
    logic [DW-1:0] rec_first, rec_eol_data, rec_eof_data;

    always #2 clk = ~clk;

    hline_clip #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sol(in_sol), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_sol(out_sol), .out_eol(out_eol), .out_eof(out_eof)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rec_clear();
        rec_cnt = 0; rec_eol_cnt = 0; rec_eof_cnt = 0; rec_sol_bad = 0;
        rec_first = '0; rec_eol_data = '0; rec_eof_data = '0;
    endtask

    task automatic push(input logic [DW-1:0] d, input logic sol, input logic eof);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sol = sol; in_eof = eof;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        if (out_valid) begin
            if (rec_cnt == 0) begin
                rec_first = out_data;
                if (!out_sol) rec_sol_bad++;
            end else if (out_sol) begin
                rec_sol_bad++;
            end
            rec_cnt++;
            if (out_eol) begin rec_eol_cnt++; rec_eol_data = out_data; end
            if (out_eof) begin rec_eof_cnt++; rec_eof_data = out_data; end
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sol = 1'b0; in_eof = 1'b0;
    endtask

    task automatic frame_end();
        push({DW{1'b1}}, 1'b1, 1'b1);
    endtask

    task automatic send_line(input logic [7:0] ln, input logic [7:0] wm1, input logic eof);
        for (int c = 0; c <= int'(wm1); c++)
            push({8'hA5, ln, 8'(c)}, c == 0, eof && (c == int'(wm1)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rec_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state is bypass
        @(negedge clk);
        #1;
        chk("R1 idle out_valid", 32'(out_valid), 32'd0);
        chk("R1 idle in_ready", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b1; in_data = 24'h123456; in_sol = 1'b1;
        #1;
        chk("R1 bypass out_valid", 32'(out_valid), 32'd1);
        chk("R1 bypass data", 32'(out_data), 32'h123456);
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sol = 1'b0;

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int vi = 0; vi < 5; vi++) begin
            cfg_write(2'd2, {8'd0, VEC[vi].left, 8'd0, VEC[vi].right});
            cfg_write(2'd1, {8'd0, VEC[vi].wm1, 16'd1});
            cfg_write(2'd0, {30'd0, 1'b0, VEC[vi].byp});
            frame_end();
            for (int ln = 0; ln < 2; ln++) begin
                rec_clear();
                send_line(8'(ln), VEC[vi].wm1, ln == 1);
                chk("R4 kept count", 32'(rec_cnt), 32'(VEC[vi].nkeep));
                chk("R3 first kept", 32'(rec_first), {8'd0, 8'hA5, 8'(ln), VEC[vi].first});
                chk("R6 sol placement", 32'(rec_sol_bad), 32'd0);
                chk("R6 eol count", 32'(rec_eol_cnt), 32'd1);
                chk("R6 eol position", 32'(rec_eol_data),
                    {8'd0, 8'hA5, 8'(ln), 8'(VEC[vi].first + VEC[vi].nkeep - 8'd1)});
                chk("R7 eof count", 32'(rec_eof_cnt), 32'(ln == 1));
                if (ln == 1)
                    chk("R7 eof position", 32'(rec_eof_data), 32'(rec_eol_data));
            end
        end

        // R8: new trim waits for end of frame
        cfg_write(2'd0, 32'd0);
        cfg_write(2'd1, {16'd3, 16'd0});
        cfg_write(2'd2, {16'd1, 16'd0});
        frame_end();
        cfg_write(2'd2, {16'd0, 16'd0});
        rec_clear(); send_line(8'd1, 8'd3, 1'b0);
        chk("R8 old window before eof", 32'(rec_first), 32'hA50101);
        frame_end();
        rec_clear(); send_line(8'd2, 8'd3, 1'b0);
        chk("R8 new window after eof", 32'(rec_first), 32'hA50200);

        // R9 R5: hold bit blocks reload
        cfg_write(2'd0, 32'd2);
        cfg_write(2'd2, {16'd2, 16'd0});
        frame_end();
        rec_clear(); send_line(8'd3, 8'd3, 1'b0);
        chk("R9 held window", 32'(rec_first), 32'hA50300);
        cfg_write(2'd0, 32'd0);
        frame_end();
        rec_clear(); send_line(8'd4, 8'd3, 1'b0);
        chk("R9 released window", 32'(rec_first), 32'hA50402);

        // R10: trimmed pixels consumed under stall, kept pixel waits
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_sol = 1'b1; in_data = 24'hA50500;
        #1;
        chk("R10 drop col0 ready", 32'(in_ready), 32'd1);
        chk("R10 drop col0 no out", 32'(out_valid), 32'd0);
        @(negedge clk);
        in_sol = 1'b0; in_data = 24'hA50501;
        #1;
        chk("R10 drop col1 ready", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_data = 24'hA50502;
        #1;
        chk("R10 kept col2 stalls", 32'(in_ready), 32'd0);
        chk("R10 kept col2 valid", 32'(out_valid), 32'd1);
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        chk("R10 kept col2 released", 32'(in_ready), 32'd1);
        @(posedge clk);
        #1;
        in_valid = 1'b0;

        // R11: sol restarts the column count mid-line
        rec_clear();
        push(24'hA50600, 1'b1, 1'b0);
        push(24'hA50601, 1'b0, 1'b0);
        rec_clear();
        push(24'hA50700, 1'b1, 1'b0);
        push(24'hA50701, 1'b0, 1'b0);
        push(24'hA50702, 1'b0, 1'b0);
        chk("R11 kept after restart", 32'(rec_cnt), 32'd1);
        chk("R11 first after restart", 32'(rec_first), 32'hA50702);
        chk("R11 sol after restart", 32'(rec_sol_bad), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule